// File: doc/BRIEF.md
# Shared-Counter PWM and Capture/Compare Timer

This block has two timebases. A narrow wrapping counter drives three pulse-width outputs, and a wider counter serves three capture/compare channels. Each counter moves forward through its own divider. The divider counts either every internal clock cycle or every rising edge of one external count-clock pin, which is first brought into the internal clock domain by a two-flop synchronizer.

Each pulse-width output is high while the shared counter is below that channel's high time. A new high time goes into a shadow register and is loaded only when the counter wraps to zero, so no period is ever cut short. Each capture/compare channel has a compare value and a capture register. When the counter equals the compare value, a sticky flag is set. A selected edge on the channel's synchronized input copies the counter into the capture register and sets a second sticky flag. Software reaches all of this through a simple single-cycle register port and clears flags by writing ones. One interrupt line is the OR of all flags.

Top module: `shared_timer`

## Requirements
- R1: After reset all PWM outputs and `irq` are low. Both dividers are 0 with the internal source, all high times and capture registers are 0, every compare value is all ones, every capture mode is 3 (off), and all flags are 0.
- R2: PWM output i is high exactly while the PWM counter is below its active high time. A high time of 0 keeps the output low, and 255 keeps it high for 255 of every 256 counts.
- R3: Writing a high time (address 2+i) updates only the shadow register. The active value is loaded from the shadow in the cycle in which the PWM counter steps from all ones to 0.
- R4: A divider with value D (bits 7:0 of address 0 for PWM, address 1 for capture/compare) advances its counter once per D+1 source events.
- R5: Bit 8 of a configuration register selects the source. When it is 0, every clock cycle is an event. When it is 1, each rising edge of `ext_clk` is an event, seen after a two-flop synchronizer and edge detection, so the step comes three clocks after the pin changes.
- R6: The capture/compare counter is CC_W bits wide and wraps. In any cycle where it equals compare value i (address 5+i), compare flag i (bit i of address 12) is set and stays set.
- R7: The capture mode of channel i sits in bits 2i+1:2i of address 11: 0 is rising, 1 is falling, 2 is both edges, 3 is off. A selected edge on the synchronized `cap_in[i]` copies the counter into capture register i (address 8+i, read only) and sets capture flag i (bit 3+i of address 12). Mode 3 changes neither.
- R8: Writing address 12 clears each flag whose data bit is 1. A flag that is set in the same cycle stays set. `irq` is high while any flag is set.
- R9: `reg_rdata` shows the register at `reg_addr` in the same cycle. Address 13 reads the capture/compare counter, address 14 reads the PWM counter, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ext_clk | input | 1 | External count-clock pin |
| cap_in | input | 3 | Capture inputs, one per channel |
| pwm_out | output | 3 | PWM outputs |
| irq | output | 1 | OR of all sticky flags |

## Verification
The bench keeps the default 8-bit PWM counter, 8-bit dividers and three channels. With these values a full PWM period at divide 1 takes 256 cycles, so many wraps and high-time reloads fall inside the run. The capture/compare counter is built 12 bits wide. This lets its wrap, and a match against the all-ones reset compare value, happen within about 4096 cycles. A wider counter would make both unreachable.

// File: rtl/shtmr_pkg.sv
package shtmr_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_PWM_CFG = 4'd0;
    localparam logic [ADDR_W-1:0] A_CC_CFG  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DUTY0   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP0    = 4'd5;
    localparam logic [ADDR_W-1:0] A_CAP0    = 4'd8;
    localparam logic [ADDR_W-1:0] A_MODE    = 4'd11;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 4'd12;
    localparam logic [ADDR_W-1:0] A_CC_CNT  = 4'd13;
    localparam logic [ADDR_W-1:0] A_PWM_CNT = 4'd14;

    typedef enum logic [1:0] {
        CAP_RISE = 2'd0,
        CAP_FALL = 2'd1,
        CAP_BOTH = 2'd2,
        CAP_OFF  = 2'd3
    } cap_mode_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[1] & ~sh_q[2];
    assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick  = evt && (pre_q == div);
        pre_d = pre_q;
        if (tick)     pre_d = '0;
        else if (evt) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/shared_timer.sv
module shared_timer
    import shtmr_pkg::*;
#(
    parameter int PWM_W = 8,
    parameter int CC_W  = 32,
    parameter int PRE_W = 8,
    parameter int NCH   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ext_clk,
    input  logic [NCH-1:0]    cap_in,
    output logic [NCH-1:0]    pwm_out,
    output logic              irq
);
    localparam int FLAG_W = 2 * NCH;

    typedef struct packed {
        logic [PWM_W-1:0]            pwm_cnt;
        logic [CC_W-1:0]             cc_cnt;
        logic [PRE_W-1:0]            pwm_div;
        logic                        pwm_ext;
        logic [PRE_W-1:0]            cc_div;
        logic                        cc_ext;
        logic [NCH-1:0][PWM_W-1:0]   shadow;
        logic [NCH-1:0][PWM_W-1:0]   active;
        logic [NCH-1:0][CC_W-1:0]    cmp;
        logic [NCH-1:0][CC_W-1:0]    cap;
        logic [NCH-1:0][1:0]         mode;
        logic [NCH-1:0]              cmp_flag;
        logic [NCH-1:0]              cap_flag;
    } state_t;

    state_t st_d, st_q;

    logic           ext_rise, ext_fall;
    logic [NCH-1:0] cap_rise, cap_fall;
    logic           pwm_tick, cc_tick;

    tmr_edge_sync u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise), .fall(ext_fall)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_cap_sync
        tmr_edge_sync u_sync (
            .clk(clk), .rst_n(rst_n), .din(cap_in[g]),
            .rise(cap_rise[g]), .fall(cap_fall[g])
        );
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pwm_pre (
        .clk(clk), .rst_n(rst_n),
        .evt(st_q.pwm_ext ? ext_rise : 1'b1),
        .div(st_q.pwm_div), .tick(pwm_tick)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_cc_pre (
        .clk(clk), .rst_n(rst_n),
        .evt(st_q.cc_ext ? ext_rise : 1'b1),
        .div(st_q.cc_div), .tick(cc_tick)
    );

    always_comb begin
        logic [NCH-1:0] cmp_set, cap_set, cmp_clr, cap_clr;
        logic           wrap;
        logic           hit;
        st_d    = st_q;
        cmp_set = '0;
        cap_set = '0;
        cmp_clr = '0;
        cap_clr = '0;
        wrap    = pwm_tick && (st_q.pwm_cnt == '1);

        if (pwm_tick) st_d.pwm_cnt = st_q.pwm_cnt + 1'b1;
        if (cc_tick)  st_d.cc_cnt  = st_q.cc_cnt + 1'b1;

        for (int i = 0; i < NCH; i++) begin
            if (wrap) st_d.active[i] = st_q.shadow[i];
            cmp_set[i] = (st_q.cc_cnt == st_q.cmp[i]);
            hit = ((st_q.mode[i] == CAP_RISE) && cap_rise[i])
               || ((st_q.mode[i] == CAP_FALL) && cap_fall[i])
               || ((st_q.mode[i] == CAP_BOTH) && (cap_rise[i] || cap_fall[i]));
            if (hit) begin
                st_d.cap[i] = st_q.cc_cnt;
                cap_set[i]  = 1'b1;
            end
        end

        if (reg_wr) begin
            if (reg_addr == A_PWM_CFG) begin
                st_d.pwm_div = reg_wdata[PRE_W-1:0];
                st_d.pwm_ext = reg_wdata[PRE_W];
            end
            if (reg_addr == A_CC_CFG) begin
                st_d.cc_div = reg_wdata[PRE_W-1:0];
                st_d.cc_ext = reg_wdata[PRE_W];
            end
            if (reg_addr == A_MODE) st_d.mode = reg_wdata[FLAG_W-1:0];
            if (reg_addr == A_FLAGS) begin
                cmp_clr = reg_wdata[NCH-1:0];
                cap_clr = reg_wdata[FLAG_W-1:NCH];
            end
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr == ADDR_W'(int'(A_DUTY0) + i)) st_d.shadow[i] = reg_wdata[PWM_W-1:0];
                if (reg_addr == ADDR_W'(int'(A_CMP0) + i))  st_d.cmp[i]    = reg_wdata[CC_W-1:0];
            end
        end

        st_d.cmp_flag = (st_q.cmp_flag & ~cmp_clr) | cmp_set;
        st_d.cap_flag = (st_q.cap_flag & ~cap_clr) | cap_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cmp  <= '1;
            st_q.mode <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_PWM_CFG)  reg_rdata = DATA_W'({st_q.pwm_ext, st_q.pwm_div});
        if (reg_addr == A_CC_CFG)   reg_rdata = DATA_W'({st_q.cc_ext, st_q.cc_div});
        if (reg_addr == A_MODE)     reg_rdata = DATA_W'(st_q.mode);
        if (reg_addr == A_FLAGS)    reg_rdata = DATA_W'({st_q.cap_flag, st_q.cmp_flag});
        if (reg_addr == A_CC_CNT)   reg_rdata = DATA_W'(st_q.cc_cnt);
        if (reg_addr == A_PWM_CNT)  reg_rdata = DATA_W'(st_q.pwm_cnt);
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == ADDR_W'(int'(A_DUTY0) + i)) reg_rdata = DATA_W'(st_q.shadow[i]);
            if (reg_addr == ADDR_W'(int'(A_CMP0) + i))  reg_rdata = DATA_W'(st_q.cmp[i]);
            if (reg_addr == ADDR_W'(int'(A_CAP0) + i))  reg_rdata = DATA_W'(st_q.cap[i]);
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) pwm_out[i] = (st_q.pwm_cnt < st_q.active[i]);
    end

    assign irq = |{st_q.cap_flag, st_q.cmp_flag};

    logic unused_fall;
    assign unused_fall = ext_fall;
endmodule

// File: rtl/shared_timer_chk.sv
module shared_timer_chk
    import shtmr_pkg::*;
#(
    parameter int PWM_W = 8,
    parameter int CC_W  = 32,
    parameter int NCH   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic [3:0]                 reg_addr,
    input logic                       irq,
    input logic [PWM_W-1:0]           pwm_cnt,
    input logic [CC_W-1:0]            cc_cnt,
    input logic [NCH-1:0][PWM_W-1:0]  active,
    input logic [NCH-1:0][CC_W-1:0]   cap,
    input logic [NCH-1:0]             cap_flag
);
    // R8: irq can only drop right after a write to the flag register
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && (reg_addr == A_FLAGS)));

    // R3: active high times change only on the wrap to zero
    p_duty_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> (pwm_cnt == '0));

    // R4: the PWM counter moves by exactly one step
    p_pwm_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwm_cnt) |-> (pwm_cnt == PWM_W'($past(pwm_cnt) + 1'b1)));

    // R6: the capture/compare counter moves by exactly one step
    p_cc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cc_cnt) |-> (cc_cnt == CC_W'($past(cc_cnt) + 1'b1)));

    for (genvar g = 0; g < NCH; g++) begin : g_cap
        // R7: a new capture value always comes with its flag
        p_cap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cap[g]) |-> cap_flag[g]);
    end
endmodule

bind shared_timer shared_timer_chk #(.PWM_W(PWM_W), .CC_W(CC_W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .irq(irq),
    .pwm_cnt(st_q.pwm_cnt), .cc_cnt(st_q.cc_cnt), .active(st_q.active),
    .cap(st_q.cap), .cap_flag(st_q.cap_flag)
);

// File: tb/tb_shared_timer.sv
`timescale 1ns/1ps
module tb_shared_timer;
    localparam int PW = 8;
    localparam int CW = 12;
    localparam int NC = 3;
    localparam int CMASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ext_clk = 1'b0;
    logic [NC-1:0] cap_in = '0;
    logic [NC-1:0] pwm_out;
    logic          irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    shared_timer #(.PWM_W(PW), .CC_W(CW), .PRE_W(8), .NCH(NC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
        .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_pcnt, m_ccnt, m_pdiv, m_cdiv, m_ppre, m_cpre;
    bit m_pext, m_cext;
    int m_shd[NC], m_act[NC], m_cmp[NC], m_cap[NC], m_mode[NC];
    bit m_cf[NC], m_kf[NC];
    bit es1, es2, es3;
    bit cs1[NC], cs2[NC], cs3[NC];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pcnt = 0; m_ccnt = 0; m_pdiv = 0; m_cdiv = 0; m_ppre = 0; m_cpre = 0;
            m_pext = 0; m_cext = 0; es1 = 0; es2 = 0; es3 = 0;
            for (int c = 0; c < NC; c++) begin
                m_shd[c] = 0; m_act[c] = 0; m_cmp[c] = CMASK; m_cap[c] = 0; m_mode[c] = 3;
                m_cf[c] = 0; m_kf[c] = 0; cs1[c] = 0; cs2[c] = 0; cs3[c] = 0;
            end
        end else begin
            bit ext_edge, pev, cev, ptk, ctk, rise, fall, hit;
            bit cset[NC], kset[NC];
            ext_edge = es2 && !es3;
            pev = m_pext ? ext_edge : 1'b1;
            cev = m_cext ? ext_edge : 1'b1;
            ptk = pev && (m_ppre == m_pdiv);
            ctk = cev && (m_cpre == m_cdiv);
            for (int c = 0; c < NC; c++) begin
                rise = cs2[c] && !cs3[c];
                fall = !cs2[c] && cs3[c];
                hit = (m_mode[c] == 0 && rise) || (m_mode[c] == 1 && fall) ||
                      (m_mode[c] == 2 && (rise || fall));
                cset[c] = (m_ccnt == m_cmp[c]);
                kset[c] = hit;
                if (hit) m_cap[c] = m_ccnt;
                if (ptk && m_pcnt == 255) m_act[c] = m_shd[c];
                cs3[c] = cs2[c]; cs2[c] = cs1[c]; cs1[c] = cap_in[c];
            end
            es3 = es2; es2 = es1; es1 = ext_clk;
            m_ppre = ptk ? 0 : (pev ? (m_ppre + 1) & 255 : m_ppre);
            m_cpre = ctk ? 0 : (cev ? (m_cpre + 1) & 255 : m_cpre);
            if (ptk) m_pcnt = (m_pcnt + 1) & 255;
            if (ctk) m_ccnt = (m_ccnt + 1) & CMASK;
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: begin m_pdiv = reg_wdata[7:0]; m_pext = reg_wdata[8]; end
                    4'd1: begin m_cdiv = reg_wdata[7:0]; m_cext = reg_wdata[8]; end
                    4'd2, 4'd3, 4'd4: m_shd[reg_addr - 2] = reg_wdata[7:0];
                    4'd5, 4'd6, 4'd7: m_cmp[reg_addr - 5] = reg_wdata & CMASK;
                    4'd11: for (int c = 0; c < NC; c++) m_mode[c] = (reg_wdata >> (2 * c)) & 3;
                    4'd12: for (int c = 0; c < NC; c++) begin
                        if (reg_wdata[c]) m_cf[c] = 0;
                        if (reg_wdata[NC + c]) m_kf[c] = 0;
                    end
                    default: ;
                endcase
            end
            for (int c = 0; c < NC; c++) begin
                if (cset[c]) m_cf[c] = 1;
                if (kset[c]) m_kf[c] = 1;
            end
        end
    end

    function automatic int ref_rd(input int a);
        int v = 0;
        case (a)
            0: v = m_pdiv | (int'(m_pext) << 8);
            1: v = m_cdiv | (int'(m_cext) << 8);
            2, 3, 4: v = m_shd[a - 2];
            5, 6, 7: v = m_cmp[a - 5];
            8, 9, 10: v = m_cap[a - 8];
            11: for (int c = 0; c < NC; c++) v |= m_mode[c] << (2 * c);
            12: for (int c = 0; c < NC; c++) v |= (int'(m_cf[c]) << c) | (int'(m_kf[c]) << (NC + c));
            13: v = m_ccnt;
            14: v = m_pcnt;
            default: v = 0;
        endcase
        return v;
    endfunction

    // per-cycle compare of PWM outputs (R2) and irq (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit any;
            any = 0;
            for (int c = 0; c < NC; c++) begin
                n_vec++;
                if (pwm_out[c] !== (m_pcnt < m_act[c])) begin
                    n_bad++;
                    $display("FAIL R2: pwm_out[%0d] got %b expected %b", c, pwm_out[c], m_pcnt < m_act[c]);
                end
                any |= m_cf[c] | m_kf[c];
            end
            n_vec++;
            if (irq !== any) begin
                n_bad++;
                $display("FAIL R8: irq got %b expected %b", irq, any);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        int exp;
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        exp = ref_rd(a);
        n_vec++;
        if (reg_rdata !== 32'(exp)) begin
            n_bad++;
            $display("FAIL %s: addr %0d got %0h expected %0h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_toggle(input int n, input int half);
        repeat (n) begin
            @(negedge clk);
            ext_clk = ~ext_clk;
            repeat (half - 1) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset values of every register
        for (int a = 0; a < 16; a++) rd_chk(a, "R1");
        // R2: three high times including 0 and 255
        wr(2, 0); wr(3, 64); wr(4, 255);
        idle(600);
        rd_chk(14, "R2");
        // R3: high time written mid-period waits for the wrap
        while (m_pcnt != 100) @(negedge clk);
        wr(3, 200);
        rd_chk(3, "R3");
        idle(300);
        wr(2, 10);
        idle(260);
        // R4: dividers
        wr(0, 3);
        idle(2100);
        rd_chk(14, "R4");
        wr(1, 2);
        idle(50);
        rd_chk(13, "R4");
        rd_chk(1, "R4");
        // R5: external count clock
        wr(0, 'h100); wr(1, 'h101);
        rd_chk(0, "R5");
        ext_toggle(40, 3);
        idle(5);
        rd_chk(14, "R5");
        rd_chk(13, "R5");
        wr(0, 0); wr(1, 0);
        // R6: compare matches
        wr(12, 'h3f);
        wr(5, (m_ccnt + 40) & CMASK);
        wr(6, (m_ccnt + 90) & CMASK);
        idle(60);
        rd_chk(12, "R6");
        idle(60);
        rd_chk(12, "R6");
        rd_chk(7, "R6");
        // R7: capture modes rise / fall / both
        wr(11, 'h24);
        rd_chk(11, "R7");
        @(negedge clk); cap_in = 3'b111;
        idle(12);
        @(negedge clk); cap_in = 3'b000;
        idle(12);
        for (int a = 8; a <= 10; a++) rd_chk(a, "R7");
        rd_chk(12, "R7");
        // R7: mode off leaves captures untouched
        wr(12, 'h38);
        wr(11, 'h3f);
        @(negedge clk); cap_in = 3'b101;
        idle(12);
        for (int a = 8; a <= 10; a++) rd_chk(a, "R7");
        rd_chk(12, "R7");
        // R8: partial and full clear
        wr(12, 'h01);
        rd_chk(12, "R8");
        wr(12, 'h3f);
        rd_chk(12, "R8");
        // R6 and R9: counter wrap and default compare match
        idle(4200);
        rd_chk(12, "R6");
        rd_chk(13, "R9");
        rd_chk(15, "R9");
        finish_run();
    end
endmodule